// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

One 32-bit timer channel with a small word-indexed register interface. Software loads a reload constant and a starting count, picks a divide ratio and enables the channel. While the run input is high, the counter steps down by one on every prescaled tick. A tick that finds the counter at zero reloads it from the constant register and latches an underflow flag. The interrupt output is high while that flag is set and the underflow interrupt enable bit is on. Software clears the flag by writing the control register with the flag bit at zero.

The control register also holds an edge-select field, a capture-enable field and a capture flag. These fields are stored and read back but have no effect on counting. A fourth register holds a capture value that software can write and read. The channel has no streaming data path, so every pin is a plain control or status signal. A write takes effect at the clock edge where `reg_wr` is high. Reads are combinational from `reg_sel`.

Top module: `reload_down_timer`

## Requirements
- R1: After reset the reload and counter registers read 0xFFFFFFFF, the control and capture registers read 0, `irq` is low, and nothing counts until `run_en` rises.
- R2: `reg_sel` picks the register, which is the byte address divided by four: 0 reload constant, 1 counter, 2 control, 3 capture.
- R3: Control bits [2:0] choose the tick rate. Codes 0 to 4 give one tick per 4, 16, 64, 256 or 1024 clock edges. The prescaler starts from zero when `run_en` rises, so the first tick falls on the edge numbered by the divisor.
- R4: Codes 5, 6 and 7 produce no ticks, so the counter holds its value.
- R5: On a tick the counter decrements. On a tick with the counter at 0, it loads the reload constant instead and sets the underflow flag.
- R6: While `run_en` is low the counter holds, the prescaler is cleared, and the flag is never set.
- R7: A write to the counter register loads the written value at that edge. The write takes priority over a tick on the same edge.
- R8: A write to the reload constant changes only the value used at the next reload. The current count is not affected.
- R9: A control write with bit 8 at 0 clears the flag. A control write with bit 8 at 1 leaves the flag unchanged. An underflow on the same edge as a clearing write wins.
- R10: `irq` equals the underflow flag AND control bit 5.
- R11: A control read returns the stored bits [9] and [7:0], the live flag in bit 8, and zeros in bits [31:10]. Writes to bits [31:10] are ignored.
- R12: A control write does not reset the prescaler. A new divisor decides from the next prescaler edge on whether a tick occurs.
- R13: The capture register stores any written value and returns it on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Channel enable; counting happens only while high |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the register selected by `reg_sel` |
| irq | output | 1 | Underflow interrupt |

## Verification
The bench sweeps every legal divisor code against run lengths just before, at, and several periods past a tick, including runs through more than one underflow. Each expected count is worked out arithmetically. An off-by-one prescaler would show a count one step early or late. Skipping the reload at zero would show a wrapped value near 0xFFFFFFFF instead of the constant. The bench changes the divisor mid-run, and a design that reset the prescaler on that write would tick several edges late. It also checks the reserved codes, a reload constant changed between underflows, flag writes with bit 8 at one and at zero, and a counter overwrite while running.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] SEL_RELOAD  = 2'd0;
  localparam logic [1:0] SEL_COUNT   = 2'd1;
  localparam logic [1:0] SEL_CTRL    = 2'd2;
  localparam logic [1:0] SEL_CAPTURE = 2'd3;

  localparam int CODE_W   = 3;
  localparam int CTRL_W   = 10;
  localparam int BIT_IE   = 5;
  localparam int BIT_FLAG = 8;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int NUM_DIV    = 5,
  parameter int BASE_SHIFT = 2,
  parameter int DIV_STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int PRE_W = BASE_SHIFT + DIV_STEP * (NUM_DIV - 1);

  logic [PRE_W-1:0]   pre_q;
  logic [NUM_DIV-1:0] hit;

  // every divisor is a power of two dividing 2**PRE_W, so wrap is seamless
  for (genvar g = 0; g < NUM_DIV; g++) begin : g_hit
    localparam int SH = BASE_SHIFT + DIV_STEP * g;
    assign hit[g] = &pre_q[SH-1:0];
  end

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_DIV; i++) begin
      if (run && code == CODE_W'(i)) tick = hit[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (!run) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             uflow
);
  assign uflow = tick && (count == '0) && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '1;
    else if (load) count <= load_val;
    else if (tick) count <= (count == '0) ? reload_val : count - 1'b1;
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              uflow,
  output logic [CNT_W-1:0]  reload_val,
  output logic [CNT_W-1:0]  capture_val,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              flag
);
  logic wr_ctrl;
  assign wr_ctrl = wr && (sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_val  <= '1;
      capture_val <= '0;
      ctrl_q      <= '0;
      flag        <= 1'b0;
    end else begin
      if (wr && sel == SEL_RELOAD)  reload_val  <= wdata;
      if (wr && sel == SEL_CAPTURE) capture_val <= wdata;
      if (wr_ctrl) begin
        ctrl_q           <= wdata[CTRL_W-1:0];
        ctrl_q[BIT_FLAG] <= 1'b0;
      end
      if (uflow)                         flag <= 1'b1;
      else if (wr_ctrl && !wdata[BIT_FLAG]) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/reload_down_timer.sv
module reload_down_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int NUM_DIV    = 5,
  parameter int BASE_SHIFT = 2,
  parameter int DIV_STEP   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq
);
  logic              tick;
  logic              uflow;
  logic              flag;
  logic [CNT_W-1:0]  count_val;
  logic [CNT_W-1:0]  reload_val;
  logic [CNT_W-1:0]  capture_val;
  logic [CTRL_W-1:0] ctrl_q;

  tmr_prescaler #(
    .NUM_DIV(NUM_DIV), .BASE_SHIFT(BASE_SHIFT), .DIV_STEP(DIV_STEP)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_en),
    .code(ctrl_q[CODE_W-1:0]), .tick(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(reg_wr && reg_sel == SEL_COUNT), .load_val(reg_wdata),
    .tick(tick), .reload_val(reload_val),
    .count(count_val), .uflow(uflow)
  );

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .uflow(uflow),
    .reload_val(reload_val), .capture_val(capture_val),
    .ctrl_q(ctrl_q), .flag(flag)
  );

  always_comb begin
    unique case (reg_sel)
      SEL_RELOAD: reg_rdata = reload_val;
      SEL_COUNT:  reg_rdata = count_val;
      SEL_CTRL: begin
        reg_rdata                 = '0;
        reg_rdata[CTRL_W-1:0]     = ctrl_q;
        reg_rdata[BIT_FLAG]       = flag;
      end
      default:    reg_rdata = capture_val;
    endcase
  end

  assign irq = flag && ctrl_q[BIT_IE];
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [CNT_W-1:0]  reg_wdata,
  input logic [CNT_W-1:0]  reg_rdata,
  input logic              irq,
  input logic              tick,
  input logic [CNT_W-1:0]  count_val,
  input logic [CNT_W-1:0]  reload_val,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              flag
);
  logic cnt_wr;
  assign cnt_wr = reg_wr && reg_sel == SEL_COUNT;

  // R7
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count_val == $past(reg_wdata));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_val == '0 && !cnt_wr) |=> (count_val == $past(reload_val)) && flag);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_wr) |=> $stable(count_val));

  // R10
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_CTRL) |-> (irq == (reg_rdata[BIT_FLAG] && reg_rdata[BIT_IE])));

  // R11
  rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_CTRL) |-> (reg_rdata[CNT_W-1:CTRL_W] == '0));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_CTRL && !reg_wdata[BIT_FLAG] && !(tick && count_val == '0))
      |=> !flag);

  // R4
  no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CODE_W-1:0] > 3'd4) |-> !tick);
endmodule

bind reload_down_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .reg_wr(reg_wr),
  .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq(irq), .tick(tick), .count_val(count_val),
  .reload_val(reload_val), .ctrl_q(ctrl_q), .flag(flag)
);

// File: tb/test_reload_down_timer.sv
module test_reload_down_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  reload_down_timer i_reload_down_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run_en = 1'b0; reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] val);
    reg_sel = sel;
    #1;
    val = reg_rdata;
  endtask

  task automatic run_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_cnt(input longint c, input longint r, input longint t);
    if (t <= c) return 32'(c - t);
    return 32'(r - ((t - c - 1) % (r + 1)));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1 R2 reset values at each word index
    rd(2'd0, v); check("R1 reload", v, 32'hFFFF_FFFF);
    rd(2'd1, v); check("R1 count", v, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R1 ctrl", v, 32'h0);
    rd(2'd3, v); check("R1 capture", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R3 R5 R10 sweep of codes and run lengths
    for (int code = 0; code < 5; code++) begin
      for (int k = 0; k < 5; k++) begin
        int dv; int n; int t;
        dv = 4 << (2 * code);
        case (k)
          0: n = dv - 1;
          1: n = dv;
          2: n = 3 * dv;
          3: n = 5 * dv + 1;
          default: n = 7 * dv;
        endcase
        t = n / dv;
        do_reset();
        wr(2'd0, 32'd2);
        wr(2'd1, 32'd3);
        wr(2'd2, 32'(code) | 32'h20);
        run_en = 1'b1;
        run_edges(n);
        rd(2'd1, v); check("R3 R5 count", v, exp_cnt(3, 2, t));
        rd(2'd2, v); check("R5 flag", {31'b0, v[8]}, {31'b0, t > 3});
        check("R10 irq", {31'b0, irq}, {31'b0, t > 3});
        run_en = 1'b0;
      end
    end

    // R4 reserved codes stall
    do_reset();
    wr(2'd1, 32'd50);
    wr(2'd2, 32'h5);
    run_en = 1'b1; run_edges(3000);
    rd(2'd1, v); check("R4 code5", v, 32'd50);
    run_en = 1'b0; @(negedge clk);
    wr(2'd2, 32'h7);
    run_en = 1'b1; run_edges(500);
    rd(2'd1, v); check("R4 code7", v, 32'd50);
    run_en = 1'b0;

    // R8 reload change between underflows; R6 hold while stopped
    do_reset();
    wr(2'd0, 32'd5); wr(2'd1, 32'd2); wr(2'd2, 32'h0);
    run_en = 1'b1; run_edges(4);
    rd(2'd1, v); check("R5 one tick", v, 32'd1);
    run_en = 1'b0; run_edges(200);
    rd(2'd1, v); check("R6 hold", v, 32'd1);
    wr(2'd0, 32'd9);
    rd(2'd1, v); check("R8 count untouched", v, 32'd1);
    run_en = 1'b1; run_edges(8);
    rd(2'd1, v); check("R8 new reload", v, 32'd9);
    run_en = 1'b0;
    rd(2'd2, v); check("R5 flag set", {31'b0, v[8]}, 32'd1);
    check("R10 irq masked", {31'b0, irq}, 32'd0);

    // R9 flag write semantics
    wr(2'd2, 32'h120);
    rd(2'd2, v); check("R9 keep flag", v, 32'h120);
    check("R10 irq on", {31'b0, irq}, 32'd1);
    wr(2'd2, 32'h020);
    rd(2'd2, v); check("R9 clear flag", v, 32'h020);
    check("R10 irq off", {31'b0, irq}, 32'd0);

    // R11 reserved bits and stored fields
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R11 ctrl read", v, 32'h0000_02FF);

    // R13 capture storage
    wr(2'd3, 32'hA5A5_1234);
    rd(2'd3, v); check("R13 capture", v, 32'hA5A5_1234);

    // R7 counter overwrite while running
    do_reset();
    wr(2'd1, 32'd100); wr(2'd2, 32'h0);
    run_en = 1'b1; run_edges(5);
    wr(2'd1, 32'd40);
    run_edges(4);
    rd(2'd1, v); check("R7 overwrite", v, 32'd39);
    run_en = 1'b0;

    // R12 divisor change keeps prescaler phase
    do_reset();
    wr(2'd1, 32'd10); wr(2'd2, 32'h0);
    run_en = 1'b1; run_edges(8);
    rd(2'd1, v); check("R12 before", v, 32'd8);
    wr(2'd2, 32'h1);
    run_edges(6);
    rd(2'd1, v); check("R12 edge15", v, 32'd8);
    run_edges(1);
    rd(2'd1, v); check("R12 edge16", v, 32'd7);
    run_en = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule